// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block counts position pulses from a two-wire incremental encoder. Both encoder wires are resynchronised to the local clock. A mode field then chooses how they are interpreted. In one mode, edges on wire A are counted and the level of wire B sets the direction. In another mode the roles of the two wires are swapped. In the third mode both wires are decoded as a Gray-code pair, which gives four counts per encoder cycle.

The count runs in a closed range from zero up to a programmable preset. Stepping up from the preset wraps the count to zero. Stepping down from zero wraps it to the preset. Every wrap produces a one-cycle event pulse.

The preset can be written straight into use. It can also be held in a buffer until the next wrap, so that a new limit never cuts an ongoing period short. Software reaches the count, the preset, the mode field and a small control word through a flat register port. The register port has a write strobe and a combinational read path.

Top module: `qenc_counter`

## Requirements
- R1: After reset, the count reads 0, the preset reads all ones, the control word reads 0, the mode field reads 0 and `eventOut` is low.
- R2: Mode code 1 (mode register, address 1, bits 2:0): every edge of A, rising or falling, moves the count by one. The count goes up while B is low and down while B is high. Edges of B alone leave the count unchanged.
- R3: Mode code 2: every edge of B moves the count by one. The count goes up while A is low and down while A is high. Edges of A alone leave the count unchanged.
- R4: Mode code 3: each of the transitions {A,B} 00→10→11→01→00 adds one to the count, and each reverse transition subtracts one, giving four counts per encoder cycle.
- R5: Mode code 3: a sample in which A and B both change leaves the count unchanged.
- R6: An up step taken while the count equals (or exceeds) the active preset loads 0, and `eventOut` is high for exactly that one cycle.
- R7: A down step taken while the count is 0 loads the active preset, and `eventOut` is high for exactly that one cycle.
- R8: Counting happens only while the enable bit (control register, address 0, bit 0) is 1.
- R9: The direction flag (control register bit 4, 0 = up, 1 = down) can be written and read back, and it takes the direction of every count step.
- R10: With the preload bit (control register bit 7) set, a write to the preset (address 3) reads back at once but becomes the wrap limit only at the next wrap. With the preload bit clear, the written preset is the limit immediately.
- R11: A write to the count (address 2) sets the count to the written value on the next clock. The write takes priority over a count step in the same cycle.
- R12: Mode codes 0 and 4 to 7 disable counting from the encoder inputs.
- R13: A change on an encoder input reaches the count at the third rising clock edge after it is applied (two synchroniser stages plus the count register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder wire A, asynchronous |
| encB | input | 1 | Encoder wire B, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 mode, 2 count, 3 preset |
| wrData | input | W | Write data |
| rdAddr | input | 2 | Read address, same map as the write address |
| rdData | output | W | Combinational read data |
| eventOut | output | 1 | One-cycle pulse on every wrap |

## Verification
The assertions assume that, after reset, the encoder inputs and the register port carry defined values and never X. They also assume that a count write is the only way the count can move by more than one step in a single cycle. The bench changes encoder levels only on falling clock edges and holds each level for at least four cycles, so no synchroniser sample is ever missed. It changes one wire at a time, except in the deliberate double-change case that tests rejection.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_MODE   = 1;
  localparam int ADDR_COUNT  = 2;
  localparam int ADDR_PRESET = 3;

  localparam int BIT_EN      = 0;
  localparam int BIT_DIR     = 4;
  localparam int BIT_PRELOAD = 7;

  localparam logic [2:0] MODE_ONA  = 3'd1;
  localparam logic [2:0] MODE_ONB  = 3'd2;
  localparam logic [2:0] MODE_QUAD = 3'd3;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic cntWrite;
    logic presetWrite;
    logic preloadOn;
  } qenc_strobe_t;
endpackage

// File: rtl/qenc_input_sync.sv
module qenc_input_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rawIn,
  output logic [1:0] syncOut,
  output logic [1:0] prevOut
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [STAGES-1:0] pipe;
    logic              prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe  <= '0;
        prevQ <= 1'b0;
      end else begin
        pipe  <= {pipe[STAGES-2:0], rawIn[ch]};
        prevQ <= pipe[STAGES-1];
      end
    end
    assign syncOut[ch] = pipe[STAGES-1];
    assign prevOut[ch] = prevQ;
  end
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   syncIn,
  input  logic [1:0]   prevIn,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output qenc_strobe_t strobes,
  output logic         ctrlEn,
  output logic         ctrlDir,
  output logic         ctrlPreload,
  output logic [2:0]   modeSel
);
  logic curA, curB, oldA, oldB;
  logic chgA, chgB;
  logic rawStep, rawDown;
  logic ctrlWr, modeWr;

  assign curA = syncIn[0];
  assign curB = syncIn[1];
  assign oldA = prevIn[0];
  assign oldB = prevIn[1];
  assign chgA = curA ^ oldA;
  assign chgB = curB ^ oldB;

  always_comb begin
    rawStep = 1'b0;
    rawDown = 1'b0;
    unique case (modeSel)
      MODE_ONA: begin
        rawStep = chgA;
        rawDown = curB;
      end
      MODE_ONB: begin
        rawStep = chgB;
        rawDown = curA;
      end
      MODE_QUAD: begin
        rawStep = chgA ^ chgB;
        rawDown = chgA ? (oldA != oldB) : (oldA == oldB);
      end
      default: begin
        rawStep = 1'b0;
        rawDown = 1'b0;
      end
    endcase
  end

  assign ctrlWr = wrEn && (wrAddr == 2'(ADDR_CTRL));
  assign modeWr = wrEn && (wrAddr == 2'(ADDR_MODE));

  assign strobes.stepUp      = ctrlEn && rawStep && !rawDown;
  assign strobes.stepDown    = ctrlEn && rawStep && rawDown;
  assign strobes.cntWrite    = wrEn && (wrAddr == 2'(ADDR_COUNT));
  assign strobes.presetWrite = wrEn && (wrAddr == 2'(ADDR_PRESET));
  assign strobes.preloadOn   = ctrlPreload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn      <= 1'b0;
      ctrlDir     <= 1'b0;
      ctrlPreload <= 1'b0;
      modeSel     <= 3'd0;
    end else begin
      if (ctrlWr) begin
        ctrlEn      <= wrData[BIT_EN];
        ctrlPreload <= wrData[BIT_PRELOAD];
      end
      if (ctrlWr)                ctrlDir <= wrData[BIT_DIR];
      else if (strobes.stepUp)   ctrlDir <= 1'b0;
      else if (strobes.stepDown) ctrlDir <= 1'b1;
      if (modeWr) modeSel <= wrData[2:0];
    end
  end
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  qenc_strobe_t strobes,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] countVal,
  output logic [W-1:0] presetAct,
  output logic [W-1:0] presetBuf,
  output logic         eventOut
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic wrapUp, wrapDown, wrapNow;

  assign wrapUp   = strobes.stepUp && (countVal >= presetAct);
  assign wrapDown = strobes.stepDown && (countVal == ZERO);
  assign wrapNow  = !strobes.cntWrite && (wrapUp || wrapDown);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
      eventOut <= 1'b0;
    end else begin
      eventOut <= wrapNow;
      if (strobes.cntWrite)      countVal <= wrData;
      else if (wrapUp)           countVal <= ZERO;
      else if (wrapDown)         countVal <= presetAct;
      else if (strobes.stepUp)   countVal <= countVal + ONE;
      else if (strobes.stepDown) countVal <= countVal - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presetAct <= '1;
      presetBuf <= '1;
    end else begin
      if (strobes.presetWrite) presetBuf <= wrData;
      if (strobes.presetWrite && !strobes.preloadOn) presetAct <= wrData;
      else if (wrapNow)                              presetAct <= presetBuf;
    end
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         encA,
  input  logic         encB,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic [1:0]   rdAddr,
  output logic [W-1:0] rdData,
  output logic         eventOut
);
  logic [1:0]   syncAB, prevAB;
  qenc_strobe_t strobes;
  logic         ctrlEn, ctrlDir, ctrlPreload;
  logic [2:0]   modeSel;
  logic [W-1:0] countVal, presetAct, presetBuf;

  qenc_input_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rstN(rstN), .rawIn({encB, encA}),
    .syncOut(syncAB), .prevOut(prevAB)
  );

  qenc_ctrl #(.W(W)) i_ctrl (
    .clk(clk), .rstN(rstN), .syncIn(syncAB), .prevIn(prevAB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strobes(strobes),
    .ctrlEn(ctrlEn), .ctrlDir(ctrlDir), .ctrlPreload(ctrlPreload),
    .modeSel(modeSel)
  );

  qenc_datapath #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .countVal(countVal), .presetAct(presetAct), .presetBuf(presetBuf),
    .eventOut(eventOut)
  );

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      2'(ADDR_CTRL): begin
        rdData[BIT_EN]      = ctrlEn;
        rdData[BIT_DIR]     = ctrlDir;
        rdData[BIT_PRELOAD] = ctrlPreload;
      end
      2'(ADDR_MODE):  rdData[2:0] = modeSel;
      2'(ADDR_COUNT): rdData = countVal;
      default:        rdData = presetBuf;
    endcase
  end
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         wrEn,
  input logic [1:0]   wrAddr,
  input logic [W-1:0] wrData,
  input logic         ctrlEn,
  input logic [2:0]   modeSel,
  input logic [1:0]   syncAB,
  input logic [1:0]   prevAB,
  input logic [W-1:0] countVal,
  input logic         eventOut
);
  logic cntWr;
  assign cntWr = wrEn && (wrAddr == 2'd2);

  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !cntWr) |=> $stable(countVal));

  // R12
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeSel == 3'd0 || modeSel > 3'd3) && !cntWr) |=> $stable(countVal));

  // R5
  double_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 3'd3 && syncAB[0] != prevAB[0] && syncAB[1] != prevAB[1] && !cntWr)
    |=> $stable(countVal));

  // R11
  count_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> (countVal == $past(wrData)));

  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr |=> (eventOut || countVal == $past(countVal)
                || countVal == W'($past(countVal) + W'(1))
                || countVal == W'($past(countVal) - W'(1))));
endmodule

bind qenc_counter qenc_counter_chk #(.W(W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ctrlEn(ctrlEn), .modeSel(modeSel), .syncAB(syncAB), .prevAB(prevAB),
  .countVal(countVal), .eventOut(eventOut)
);

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  localparam int W = 16;
  logic clk = 1'b0, rstN = 1'b0, encA = 1'b0, encB = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [W-1:0] wrData = '0, rdData;
  logic eventOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qenc_counter #(.W(W)) i_qenc_counter (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .eventOut(eventOut)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic regRead(logic [1:0] a, output logic [W-1:0] d);
    rdAddr = a; #1 d = rdData;
  endtask

  // drive new levels, wait three rising edges (R13), check count and pulse
  task automatic move(logic na, logic nb, logic [W-1:0] expCnt, logic expEvt, string req);
    logic [W-1:0] v;
    encA = na; encB = nb;
    repeat (3) @(negedge clk);
    regRead(2'd2, v);
    check(req, v, expCnt);
    check(req, W'(eventOut), W'(expEvt));
    @(negedge clk);
    check(req, W'(eventOut), '0);
  endtask

  task automatic quadFwd(logic [W-1:0] exp, logic evt, string req);
    if (encA == encB) move(~encA, encB, exp, evt, req);
    else move(encA, ~encB, exp, evt, req);
  endtask

  task automatic quadRev(logic [W-1:0] exp, logic evt, string req);
    if (encA == encB) move(encA, ~encB, exp, evt, req);
    else move(~encA, encB, exp, evt, req);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    regRead(2'd2, v); check("R1 count", v, '0);
    regRead(2'd3, v); check("R1 preset", v, '1);
    regRead(2'd0, v); check("R1 ctrl", v, '0);
    regRead(2'd1, v); check("R1 mode", v, '0);
    check("R1 event", W'(eventOut), '0);
  endtask

  task automatic t_chanA();
    logic [W-1:0] v;
    regWrite(2'd1, 16'd1);
    regWrite(2'd0, 16'h0001);
    move(1, 0, 16'd1, 0, "R2 A rise up");
    move(0, 0, 16'd2, 0, "R2 A fall up");
    move(0, 1, 16'd2, 0, "R2 B edge ignored");
    move(1, 1, 16'd1, 0, "R2 A rise down");
    regRead(2'd0, v); check("R9 dir after down", W'(v[4]), 16'd1);
    move(0, 1, 16'd0, 0, "R2 A fall down");
  endtask

  task automatic t_chanB();
    logic [W-1:0] v;
    regWrite(2'd1, 16'd2);
    regWrite(2'd2, 16'd10);
    move(0, 0, 16'd11, 0, "R3 B fall up");
    move(1, 0, 16'd11, 0, "R3 A edge ignored");
    move(1, 1, 16'd10, 0, "R3 B rise down");
    move(0, 1, 16'd10, 0, "R3 A edge ignored 2");
    move(0, 0, 16'd11, 0, "R3 B fall up 2");
    regRead(2'd0, v); check("R9 dir after up", W'(v[4]), 16'd0);
  endtask

  task automatic t_quad();
    regWrite(2'd1, 16'd3);
    regWrite(2'd2, 16'd0);
    for (int i = 1; i <= 4; i++) quadFwd(W'(i), 0, "R4 forward");
    for (int i = 3; i >= 0; i--) quadRev(W'(i), 0, "R4 reverse");
    move(1, 1, 16'd0, 0, "R5 double change");
    move(0, 0, 16'd0, 0, "R5 double change back");
  endtask

  task automatic t_wrap();
    regWrite(2'd3, 16'd5);
    regWrite(2'd2, 16'd5);
    quadFwd(16'd0, 1, "R6 up wrap");
    quadRev(16'd5, 1, "R7 down wrap");
  endtask

  task automatic t_preload();
    logic [W-1:0] v;
    regWrite(2'd0, 16'h0081);
    regWrite(2'd3, 16'd2);
    regRead(2'd3, v); check("R10 buffered readback", v, 16'd2);
    regWrite(2'd2, 16'd4);
    quadFwd(16'd5, 0, "R10 old limit still used");
    quadFwd(16'd0, 1, "R10 wrap at old limit");
    quadFwd(16'd1, 0, "R10 after reload");
    quadFwd(16'd2, 0, "R10 after reload 2");
    quadFwd(16'd0, 1, "R10 wrap at new limit");
    regWrite(2'd0, 16'h0001);
    regWrite(2'd3, 16'd1);
    quadFwd(16'd1, 0, "R10 immediate");
    quadFwd(16'd0, 1, "R10 immediate wrap");
  endtask

  task automatic t_enable();
    logic [W-1:0] v;
    regWrite(2'd2, 16'd0);
    regWrite(2'd0, 16'h0000);
    quadFwd(16'd0, 0, "R8 disabled");
    regWrite(2'd0, 16'h0010);
    regRead(2'd0, v); check("R9 dir write", v, 16'h0010);
  endtask

  task automatic t_badMode();
    regWrite(2'd0, 16'h0001);
    regWrite(2'd1, 16'd0);
    quadFwd(16'd0, 0, "R12 mode 0");
    regWrite(2'd1, 16'd5);
    quadFwd(16'd0, 0, "R12 mode 5");
  endtask

  task automatic t_countWrite();
    logic [W-1:0] v;
    regWrite(2'd2, 16'h1234);
    regRead(2'd2, v); check("R11 count write", v, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_chanA();
    t_chanB();
    encA = 0; encB = 0;
    repeat (4) @(negedge clk);
    t_quad();
    t_wrap();
    t_preload();
    t_enable();
    t_badMode();
    t_countWrite();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule